// File: doc/BRIEF.md
# Word-Auto-Increment Flash Program Sequencer

This block writes a run of bytes into a serial flash whose bulk write command is a two-byte auto-address-increment word program rather than a page program. The caller supplies a start address and a byte count on a request port. The data bytes are pulled from a valid/ready byte stream. The block turns the request into flash transactions and hands them one byte at a time to an SPI byte engine. That engine owns chip select and the serial clock.

The block first waits for the flash to become idle and then sets the write-enable latch. An odd start address is covered by a single byte-program command. The even-aligned body goes out as word commands, and only the first word command carries the address. The word phase ends with write-disable. A byte left over at the end gets its own write-enable, byte program and write-disable. After every programming step the status register is read again and again until its busy bit clears. If the flash stays busy for too many reads, the job is abandoned and an error is flagged.

Top module: `wordprog_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `spi_req`, `done` and `error` are 0. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` stays low until the job ends.
- R2: Every job opens with a status read: a two-byte transaction of opcode 0x05 followed by a dummy byte, where bit 0 of the byte returned for the dummy is the busy flag (1 = busy). Once that flag reads 0, a one-byte write-enable transaction (0x06) follows.
- R3: When the start address is odd and the length is nonzero, the first program command is 0x02, then the address in ADDR_BYTES bytes with the most significant byte first, then one data byte. The running address then moves up by one.
- R4: Word program commands use opcode 0xAD. The first one carries opcode, address (most significant byte first) and two data bytes. Every later one carries only the opcode and two data bytes.
- R5: Word commands keep being issued while two or more bytes remain. Data bytes are sent in stream order, and the address wraps modulo 2^(8*ADDR_BYTES).
- R6: When the word phase ends, a one-byte write-disable transaction (0x04) is sent, followed by a status read.
- R7: If one byte remains after the word phase, the block sends write-enable (0x06), then 0x02 with the full address of that byte and the byte itself, then a status read, then write-disable (0x04). With no byte remaining, the job ends after the status read of R6.
- R8: After each program command, no transaction other than a status read is issued until a status read has returned the busy flag at 0.
- R9: If POLL_MAX status reads in a row return busy, the job stops. `error` pulses for one cycle, `done` stays low, and the block returns to idle.
- R10: A job that succeeds ends with a one-cycle `done` pulse. `wr_count` then equals the requested length, and after an error it holds the number of data bytes already sent.
- R11: `spi_last` is high exactly on the final byte of each transaction. While `spi_req` is high and not yet acknowledged, `spi_tx` and `spi_last` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Job request |
| req_ready | output | 1 | Idle, able to take a job |
| req_addr | input | 8*ADDR_BYTES | Flash start address |
| req_len | input | LEN_W | Number of data bytes |
| dat_valid | input | 1 | Data byte available |
| dat_byte | input | 8 | Data byte |
| dat_ready | output | 1 | Data byte consumed this cycle |
| spi_req | output | 1 | Byte transfer request to the SPI engine |
| spi_tx | output | 8 | Byte to shift out |
| spi_last | output | 1 | Byte ends the transaction (release chip select) |
| spi_ack | input | 1 | Transfer of the current byte complete |
| spi_rx | input | 8 | Byte shifted in during the acknowledged transfer |
| done | output | 1 | Job completed (pulse) |
| error | output | 1 | Job aborted on busy timeout (pulse) |
| wr_count | output | LEN_W | Data bytes sent in the last job |

## Verification
The bench targets the parity cases. It tries odd and even starts with lengths of zero, one and two, and a single trailing byte after an odd head. If the head or tail test were wrong, bytes would land at shifted addresses, or the lone byte would be sent as a word command. It also checks that the address is never repeated on the second and later word commands, and that the tail address advances across the word phase and across the top of the address space. A stale running address would show up as a wrong tail address. Busy replies of varying length and a flash that never becomes ready test the poll counter and the abort path. A sequencer that skipped a status read would be caught issuing a command while the flash model is busy.

// File: rtl/wordprog_seq.sv
module wordprog_seq #(
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 16,
  parameter int POLL_MAX   = 1024
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [8*ADDR_BYTES-1:0] req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    dat_valid,
  input  logic [7:0]              dat_byte,
  output logic                    dat_ready,
  output logic                    spi_req,
  output logic [7:0]              spi_tx,
  output logic                    spi_last,
  input  logic                    spi_ack,
  input  logic [7:0]              spi_rx,
  output logic                    done,
  output logic                    error,
  output logic [LEN_W-1:0]        wr_count
);
  localparam int AW   = 8 * ADDR_BYTES;
  localparam int BI_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int PW   = $clog2(POLL_MAX + 1);

  localparam logic [7:0] OP_RDST = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_BYTE = 8'h02;
  localparam logic [7:0] OP_WORD = 8'hAD;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL_OP, S_POLL_RD, S_WREN, S_WRDI,
    S_BP_OP, S_BP_AD, S_BP_DT, S_WP_OP, S_WP_AD, S_WP_D0, S_WP_D1
  } st_t;

  typedef enum logic [1:0] {PH_INIT, PH_BODY, PH_FLUSH, PH_TAIL} ph_t;

  st_t              st;
  ph_t              ph;
  logic [AW-1:0]    addr;
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] cnt;
  logic [BI_W-1:0]  bi;
  logic [PW-1:0]    pcnt;
  logic             first;
  logic             done_q, err_q;

  wire unused_rx = ^spi_rx[7:1];

  wire        data_st   = (st == S_BP_DT) || (st == S_WP_D0) || (st == S_WP_D1);
  wire        last_ab   = (bi == BI_W'(ADDR_BYTES - 1));
  wire [7:0]  addr_byte = addr[8*(ADDR_BYTES-1-int'(bi)) +: 8];
  wire        took      = data_st && spi_ack;

  st_t body_next;
  always_comb begin
    if (addr[0] && rem != '0)   body_next = S_BP_OP;
    else if (rem > LEN_W'(1))   body_next = S_WP_OP;
    else                        body_next = S_WRDI;
  end

  always_comb begin
    spi_tx   = 8'h00;
    spi_last = 1'b0;
    case (st)
      S_POLL_OP: spi_tx = OP_RDST;
      S_POLL_RD: begin spi_tx = 8'h00;   spi_last = 1'b1; end
      S_WREN:    begin spi_tx = OP_WREN; spi_last = 1'b1; end
      S_WRDI:    begin spi_tx = OP_WRDI; spi_last = 1'b1; end
      S_BP_OP:   spi_tx = OP_BYTE;
      S_WP_OP:   spi_tx = OP_WORD;
      S_BP_AD,
      S_WP_AD:   spi_tx = addr_byte;
      S_WP_D0:   spi_tx = dat_byte;
      S_BP_DT,
      S_WP_D1:   begin spi_tx = dat_byte; spi_last = 1'b1; end
      default:   ;
    endcase
  end

  assign spi_req   = (st != S_IDLE) && (!data_st || dat_valid);
  assign dat_ready = took;
  assign req_ready = (st == S_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign wr_count  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= PH_INIT;
      addr   <= '0;
      rem    <= '0;
      cnt    <= '0;
      bi     <= '0;
      pcnt   <= '0;
      first  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (took) begin
        addr <= addr + AW'(1);
        rem  <= rem - LEN_W'(1);
        cnt  <= cnt + LEN_W'(1);
      end
      case (st)
        S_IDLE: if (req_valid) begin
          addr  <= req_addr;
          rem   <= req_len;
          cnt   <= '0;
          first <= 1'b1;
          pcnt  <= '0;
          ph    <= PH_INIT;
          st    <= S_POLL_OP;
        end
        S_POLL_OP: if (spi_ack) st <= S_POLL_RD;
        S_POLL_RD: if (spi_ack) begin
          if (!spi_rx[0]) begin
            pcnt <= '0;
            case (ph)
              PH_INIT:  begin st <= S_WREN; ph <= PH_BODY; end
              PH_BODY:  st <= body_next;
              PH_FLUSH: if (rem == LEN_W'(1)) begin
                          st <= S_WREN; ph <= PH_TAIL;
                        end else begin
                          st <= S_IDLE; done_q <= 1'b1;
                        end
              default:  st <= S_WRDI;
            endcase
          end else if (pcnt == PW'(POLL_MAX - 1)) begin
            st    <= S_IDLE;
            err_q <= 1'b1;
          end else begin
            pcnt <= pcnt + PW'(1);
            st   <= S_POLL_OP;
          end
        end
        S_WREN: if (spi_ack) st <= (ph == PH_TAIL) ? S_BP_OP : body_next;
        S_WRDI: if (spi_ack) begin
          if (ph == PH_TAIL) begin
            st <= S_IDLE; done_q <= 1'b1;
          end else begin
            st <= S_POLL_OP; ph <= PH_FLUSH;
          end
        end
        S_BP_OP: if (spi_ack) begin st <= S_BP_AD; bi <= '0; end
        S_BP_AD: if (spi_ack) begin
          if (last_ab) st <= S_BP_DT;
          else         bi <= bi + BI_W'(1);
        end
        S_BP_DT: if (spi_ack) st <= S_POLL_OP;
        S_WP_OP: if (spi_ack) begin
          bi <= '0;
          st <= first ? S_WP_AD : S_WP_D0;
        end
        S_WP_AD: if (spi_ack) begin
          if (last_ab) st <= S_WP_D0;
          else         bi <= bi + BI_W'(1);
        end
        S_WP_D0: if (spi_ack) st <= S_WP_D1;
        S_WP_D1: if (spi_ack) begin
          first <= 1'b0;
          st    <= S_POLL_OP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wordprog_seq_chk.sv
module wordprog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       dat_ready,
  input logic       spi_req,
  input logic [7:0] spi_tx,
  input logic       spi_last,
  input logic       spi_ack,
  input logic       done,
  input logic       error
);
  // R11
  spi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req && !spi_ack |=> spi_req && $stable(spi_tx) && $stable(spi_last));

  // R1
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> !req_ready);

  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !error);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> req_ready && !spi_req && !error);

  // R5
  dat_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> spi_req && spi_ack);
endmodule

bind wordprog_seq wordprog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .dat_ready(dat_ready),
  .spi_req(spi_req), .spi_tx(spi_tx), .spi_last(spi_last), .spi_ack(spi_ack),
  .done(done), .error(error)
);

// File: tb/wordprog_seq_bench.sv
module wordprog_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AB = 3;
  localparam int LW = 16;
  localparam int PMAX = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [8*AB-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic dat_valid, dat_ready;
  logic [7:0] dat_byte;
  logic spi_req, spi_last, spi_ack = 0;
  logic [7:0] spi_tx, spi_rx = 0;
  logic done, error;
  logic [LW-1:0] wr_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  wordprog_seq #(.ADDR_BYTES(AB), .LEN_W(LW), .POLL_MAX(PMAX)) u_wordprog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .dat_valid(dat_valid),
    .dat_byte(dat_byte), .dat_ready(dat_ready), .spi_req(spi_req),
    .spi_tx(spi_tx), .spi_last(spi_last), .spi_ack(spi_ack), .spi_rx(spi_rx),
    .done(done), .error(error), .wr_count(wr_count));

  int checks = 0, fails = 0;
  logic [7:0] data_mem [0:63];
  logic [LW-1:0] cur_len = '0;
  logic active = 0, k_clr = 0;
  int k = 0;
  assign dat_valid = active && (k < int'(cur_len));
  assign dat_byte  = data_mem[k[5:0]];
  always @(posedge clk) begin
    if (k_clr) k <= 0;
    else if (dat_valid && dat_ready) k <= k + 1;
  end

  logic [8:0] exp_q[$];
  logic [8:0] got_q[$];
  logic [7:0] cur[$];
  int busy_polls = 0, wip = 0, prog_cnt = 0, viol = 0, stuck_at = 0;
  bit stuck_en = 0, first_seen = 0;
  logic [7:0] first_op = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_txn();
    if (!first_seen) begin first_seen = 1; first_op = cur[0]; end
    if (cur[0] != 8'h05) begin
      if (wip > 0) viol++;
      foreach (cur[i]) got_q.push_back({(i == cur.size() - 1), cur[i]});
      if (cur[0] == 8'h02 || cur[0] == 8'hAD) begin
        prog_cnt++;
        wip = busy_polls;
      end
    end
    cur.delete();
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (spi_req) begin
        logic [7:0] b, r;
        logic l;
        int lat;
        b = spi_tx; l = spi_last;
        r = 8'($urandom);
        if (cur.size() == 1 && cur[0] == 8'h05) begin
          if ((stuck_en && prog_cnt >= stuck_at) || wip > 0) r = 8'hFF;
          else r = 8'hFE;
          if (wip > 0) wip--;
        end
        lat = $urandom_range(0, 2);
        repeat (lat) @(negedge clk);
        spi_rx = r; spi_ack = 1;
        cur.push_back(b);
        if (l) finish_txn();
        @(negedge clk);
        spi_ack = 0;
      end
    end
  end

  function automatic void push_addr(input logic [8*AB-1:0] a);
    for (int j = 0; j < AB; j++) exp_q.push_back({1'b0, a[8*(AB-1-j) +: 8]});
  endfunction

  function automatic void build(input logic [8*AB-1:0] a0, input int len);
    logic [8*AB-1:0] a;
    int r, i;
    bit fw;
    exp_q.delete();
    a = a0; r = len; i = 0; fw = 1;
    exp_q.push_back({1'b1, 8'h06});
    if (a[0] && r > 0) begin
      exp_q.push_back({1'b0, 8'h02}); push_addr(a);
      exp_q.push_back({1'b1, data_mem[i]});
      i++; a = a + 1; r--;
    end
    while (r >= 2) begin
      exp_q.push_back({1'b0, 8'hAD});
      if (fw) push_addr(a);
      exp_q.push_back({1'b0, data_mem[i]});
      exp_q.push_back({1'b1, data_mem[i+1]});
      i += 2; a = a + 2; r -= 2; fw = 0;
    end
    exp_q.push_back({1'b1, 8'h04});
    if (r == 1) begin
      exp_q.push_back({1'b1, 8'h06});
      exp_q.push_back({1'b0, 8'h02}); push_addr(a);
      exp_q.push_back({1'b1, data_mem[i]});
      exp_q.push_back({1'b1, 8'h04});
    end
  endfunction

  task automatic run(input logic [8*AB-1:0] a, input int len, input int bp,
                     input bit st_en, input int st_at, input int err_items,
                     input int err_cnt, input string tag);
    int cyc, n;
    bit got_done, got_err;
    for (int i = 0; i < 64; i++) data_mem[i] = 8'($urandom);
    build(a, len);
    got_q.delete(); cur.delete();
    busy_polls = bp; wip = 0; prog_cnt = 0; viol = 0;
    stuck_en = st_en; stuck_at = st_at; first_seen = 0;
    @(negedge clk); k_clr = 1; cur_len = LW'(len);
    @(negedge clk); k_clr = 0; active = 1;
    chk(req_ready == 1'b1, {tag, " R1 ready before request"}, req_ready, 1);
    req_valid = 1; req_addr = a; req_len = LW'(len);
    @(negedge clk); req_valid = 0;
    chk(req_ready == 1'b0, {tag, " R1 busy after accept"}, req_ready, 0);
    got_done = 0; got_err = 0; cyc = 0;
    while (!got_done && !got_err && cyc < 20000) begin
      @(negedge clk);
      got_done = done; got_err = error; cyc++;
    end
    if (cyc >= 20000) chk(0, {tag, " job never finished"}, cyc, 0);
    active = 0;
    chk(first_op == 8'h05, {tag, " R2 opens with status read"}, first_op, 8'h05);
    chk(viol == 0, {tag, " R8 command while busy"}, viol, 0);
    if (!st_en) begin
      chk(got_done && !got_err, {tag, " R10 done without error"}, {got_done, got_err}, 2'b10);
      chk(wr_count == LW'(len), {tag, " R10 count"}, wr_count, len);
      n = (got_q.size() > exp_q.size()) ? got_q.size() : exp_q.size();
      chk(got_q.size() == exp_q.size(), {tag, " R3 R4 R5 R6 R7 transaction length"}, got_q.size(), exp_q.size());
      for (int i = 0; i < n; i++) begin
        if (i >= got_q.size() || i >= exp_q.size() || got_q[i] !== exp_q[i]) begin
          chk(0, {tag, " R3 R4 R5 R6 R7 R11 byte stream"},
              (i < got_q.size()) ? got_q[i] : 9'h1FF, (i < exp_q.size()) ? exp_q[i] : 9'h1FF);
          break;
        end
      end
      if (n == 0 || got_q.size() == exp_q.size()) chk(1, tag, 0, 0);
    end else begin
      chk(got_err && !got_done, {tag, " R9 timeout error"}, {got_done, got_err}, 2'b01);
      chk(wr_count == LW'(err_cnt), {tag, " R10 count at error"}, wr_count, err_cnt);
      chk(got_q.size() == err_items, {tag, " R9 transactions before abort"}, got_q.size(), err_items);
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
        if (got_q[i] !== exp_q[i]) begin
          chk(0, {tag, " R9 prefix"}, got_q[i], exp_q[i]);
          break;
        end
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !spi_req, {tag, " R1 idle after job"}, {req_ready, spi_req}, 2'b10);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired R10 actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(!spi_req && !done && !error, "R1 reset outputs", {spi_req, done, error}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(24'h000100, 0, 1, 0, 0, 0, 0, "len0_even");
    run(24'h000101, 0, 0, 0, 0, 0, 0, "len0_odd");
    run(24'h000203, 1, 2, 0, 0, 0, 0, "R3 odd_len1");
    run(24'h000204, 1, 1, 0, 0, 0, 0, "R7 even_len1");
    run(24'h000305, 2, 3, 0, 0, 0, 0, "R7 odd_len2");
    run(24'h000306, 2, 0, 0, 0, 0, 0, "R4 even_len2");
    run(24'h001001, 7, 2, 0, 0, 0, 0, "R5 odd_len7");
    run(24'h001000, 8, 1, 0, 0, 0, 0, "R4 even_len8");
    run(24'h002003, 6, 3, 0, 0, 0, 0, "R7 odd_len6");
    run(24'hFFFFFF, 3, 1, 0, 0, 0, 0, "R5 wrap_odd");
    run(24'hFFFFFC, 5, 2, 0, 0, 0, 0, "R5 wrap_even");
    run(24'h000400, 4, 0, 1, 0, 0, 0, "R9 stuck_start");
    run(24'h000100, 6, 0, 1, 1, 7, 2, "R9 stuck_word");
    for (int t = 0; t < 20; t++)
      run(24'($urandom), $urandom_range(0, 40), $urandom_range(0, 3), 0, 0, 0, 0, "rand");
    summary();
  end
endmodule